// File: doc/BRIEF.md
# Extended-Dividend Unsigned Divider

This block divides a 128-bit unsigned dividend by a 64-bit unsigned divisor. The dividend's upper half comes from a separate high-word operand, and its lower half from the ordinary operand. The block returns a 64-bit quotient and a 64-bit remainder. The divisor is either a full 64-bit operand or an 8-bit immediate that is zero-extended. No case raises a fault.

When the high word is greater than or equal to the divisor, the quotient cannot fit in 64 bits. A zero divisor always lands in this case. The block then skips the division: the high word comes back as the quotient and the low word as the remainder. The overflow test is made when the operation is accepted. Every operation, bypassed or not, reports its result exactly 60 cycles after acceptance.

The input side is a valid/ready handshake. `in_ready` equals the inverse of `busy`, and a transfer happens on a rising edge where both `in_valid` and `in_ready` are high. The upstream side must hold its operands until that edge, and any request offered while busy is not taken. The output side has no back-pressure. `out_valid` is a one-cycle pulse, and the result stays on `out_quot`/`out_rem` until the next operation is accepted.

Top module: `ext_udiv`

## Requirements
- R1: `in_ready` is the inverse of `busy`. An operation is accepted only on an edge where `in_valid && in_ready`. `busy` is high in the cycle after acceptance, and `in_valid` and the operands have no effect while `busy` is high.
- R2: `out_valid` pulses for exactly one cycle. It goes high on the 60th rising edge after the accepting edge, and `busy` falls on that same edge.
- R3: When the high word D is less than the divisor, `out_quot` = floor({D,Y}/divisor) and `out_rem` = {D,Y} mod divisor.
- R4: When D >= divisor, `out_quot` = D and `out_rem` = Y.
- R5: A divisor of zero gives `out_quot` = D and `out_rem` = Y, with the same 60-cycle latency.
- R6: With `in_use_imm` = 1, the divisor is `in_imm` zero-extended to 64 bits, and `in_divisor` has no effect.
- R7: With D = 0 and a divisor of 2^t, `out_quot` = Y >> t and `out_rem` = Y & (2^t - 1).
- R8: After `out_valid`, `out_quot` and `out_rem` hold their values until the next accepted operation.
- R9: After reset, `busy` = 0, `in_ready` = 1, `out_valid` = 0, and both result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Block can accept an operation |
| in_use_imm | input | 1 | 1: the divisor is the immediate byte |
| in_high | input | 64 | Upper dividend word D |
| in_low | input | 64 | Lower dividend word Y |
| in_divisor | input | 64 | Register divisor |
| in_imm | input | 8 | Immediate divisor byte |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | One-cycle result pulse |
| out_quot | output | 64 | Quotient, or D on bypass |
| out_rem | output | 64 | Remainder, or Y on bypass |

## Verification
The assertions check the following on every cycle:
- `busy` rises after an accepted request.
- The done pulse lasts a single cycle and coincides with `busy` falling.
- The partial remainder stays below the latched divisor on every iteration.
- The latched state is frozen in bypass.
- The results hold between operations.

The bench scenarios cover what the assertions cannot:
- The exact 60-edge latency.
- The arithmetic values compared against a 128-bit reference, across random and directed operands.
- The power-of-two identities, the zero and immediate divisors, and the insensitivity to requests offered while busy.

// File: rtl/ext_udiv_pkg.sv
package ext_udiv_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ext_udiv_bitstep.sv
// One radix-2 restoring step: shift in next dividend bit, trial subtract.
module ext_udiv_bitstep #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;  // W+1 bits so the trial cannot drop its carry
  logic         fits;
  logic [W-1:0] diff;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    fits    = shifted >= {1'b0, div_i};
    diff    = shifted[W-1:0] - div_i;
    rem_o   = fits ? diff : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/ext_udiv_seq.sv
module ext_udiv_seq
  import ext_udiv_pkg::*;
#(
  parameter int LATENCY = 60,
  parameter int STEPS   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic iter_en
);
  localparam int CW = $clog2(LATENCY);
  localparam logic [CW-1:0] CNT_LOAD    = CW'(LATENCY - 1);
  localparam logic [CW-1:0] ITER_FLOOR  = CW'(LATENCY - 1 - STEPS);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_RUN;
          cnt_q   <= CNT_LOAD;
        end
        SEQ_RUN: if (cnt_q == '0) begin
          state_q <= SEQ_IDLE;
          done    <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy    = (state_q == SEQ_RUN);
  assign iter_en = busy && (cnt_q > ITER_FLOOR);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R2
endmodule

// File: rtl/ext_udiv_datapath.sv
module ext_udiv_datapath #(
  parameter int W   = 64,
  parameter int BPC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         iter_en,
  input  logic [W-1:0] high_i,
  input  logic [W-1:0] low_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q, quo_q, div_q;
  logic         byp_q;
  logic [W-1:0] rem_c [BPC+1];
  logic [W-1:0] quo_c [BPC+1];

  assign rem_c[0] = rem_q;
  assign quo_c[0] = quo_q;

  for (genvar s = 0; s < BPC; s++) begin : g_step
    ext_udiv_bitstep #(.W(W)) u_step (
      .rem_i (rem_c[s]),
      .quo_i (quo_c[s]),
      .div_i (div_q),
      .rem_o (rem_c[s+1]),
      .quo_o (quo_c[s+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
      byp_q <= 1'b0;
    end else if (load) begin
      rem_q <= high_i;
      quo_q <= low_i;
      div_q <= div_i;
      byp_q <= (high_i >= div_i);
    end else if (iter_en && !byp_q) begin
      rem_q <= rem_c[BPC];
      quo_q <= quo_c[BPC];
    end
  end

  assign quot_o = byp_q ? rem_q : quo_q;
  assign rem_o  = byp_q ? quo_q : rem_q;

  AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_en && !byp_q) |-> (rem_q < div_q)); // R3
  AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_q && !load) |=> ($stable(rem_q) && $stable(quo_q))); // R4
endmodule

// File: rtl/ext_udiv.sv
module ext_udiv #(
  parameter int DATA_W         = 64,
  parameter int IMM_W          = 8,
  parameter int LATENCY        = 60,
  parameter int BITS_PER_CYCLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_use_imm,
  input  logic [DATA_W-1:0] in_high,
  input  logic [DATA_W-1:0] in_low,
  input  logic [DATA_W-1:0] in_divisor,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              busy,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_quot,
  output logic [DATA_W-1:0] out_rem
);
  localparam int STEPS = DATA_W / BITS_PER_CYCLE;

  logic              accept;
  logic              iter_en;
  logic [DATA_W-1:0] div_eff;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign div_eff  = in_use_imm ? {{(DATA_W-IMM_W){1'b0}}, in_imm} : in_divisor;

  ext_udiv_seq #(.LATENCY(LATENCY), .STEPS(STEPS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .busy    (busy),
    .done    (out_valid),
    .iter_en (iter_en)
  );

  ext_udiv_datapath #(.W(DATA_W), .BPC(BITS_PER_CYCLE)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .iter_en (iter_en),
    .high_i  (in_high),
    .low_i   (in_low),
    .div_i   (div_eff),
    .quot_o  (out_quot),
    .rem_o   (out_rem)
  );

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(accept)) |-> ($stable(out_quot) && $stable(out_rem))); // R8
endmodule

// File: tb/ext_udiv_tb_top.sv
`timescale 1ns/1ps
module ext_udiv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_use_imm = 1'b0;
  logic [63:0] in_high = '0, in_low = '0, in_divisor = '0;
  logic [7:0]  in_imm = '0;
  logic        busy, out_valid;
  logic [63:0] out_quot, out_rem;
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  ext_udiv dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_use_imm(in_use_imm), .in_high(in_high), .in_low(in_low),
    .in_divisor(in_divisor), .in_imm(in_imm), .busy(busy),
    .out_valid(out_valid), .out_quot(out_quot), .out_rem(out_rem)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_div(input logic [63:0] d, input logic [63:0] y, input logic [63:0] z);
    logic [127:0] num;
    num = {d, y};
    if (d >= z) return {d, y};
    return {64'(num / {64'd0, z}), 64'(num % {64'd0, z})};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic run_op(input logic [63:0] d, input logic [63:0] y, input logic [63:0] z,
                        input logic [7:0] imm, input bit use_imm, input bit junk,
                        input bit pow2, input int t, input string tag);
    logic [63:0] zeff, eq, er, q0;
    logic [127:0] res;
    bit early;
    zeff = use_imm ? {56'd0, imm} : z;
    res  = ref_div(d, y, zeff);
    eq   = res[127:64];
    er   = res[63:0];
    early = 0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready when idle", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_use_imm = use_imm; in_high = d; in_low = y;
    in_divisor = z; in_imm = imm;
    @(posedge clk); #1;
    chk(busy == 1'b1 && in_ready == 1'b0, "R1 busy after accept", 64'(busy), 64'd1);
    in_valid = junk;
    if (junk) begin
      in_high = rnd64(); in_low = rnd64(); in_divisor = rnd64();
      in_imm = 8'($urandom()); in_use_imm = ~use_imm;
    end
    for (int i = 1; i <= 60; i++) begin
      @(posedge clk); #1;
      if (i == 58) in_valid = 1'b0;
      if (i < 60 && out_valid) early = 1;
    end
    chk(!early, "R2 no early out_valid", 64'(early), 64'd0);
    chk(out_valid == 1'b1 && busy == 1'b0, "R2 done at edge 60", 64'({out_valid, busy}), 64'd2);
    chk(out_quot == eq, {tag, " quotient"}, out_quot, eq);
    chk(out_rem == er, {tag, " remainder"}, out_rem, er);
    if (pow2) begin
      chk(out_quot == (y >> t), "R7 shift quotient", out_quot, y >> t);
      chk(out_rem == (y & ((64'd1 << t) - 64'd1)), "R7 mask remainder", out_rem, y & ((64'd1 << t) - 64'd1));
    end
    q0 = out_quot;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R2 single pulse", 64'(out_valid), 64'd0);
    @(posedge clk); #1;
    chk(out_quot == q0 && out_rem == er, "R8 result held", out_quot, q0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] z, d;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0 && in_ready == 1 && out_valid == 0, "R9 reset control", 64'({busy, in_ready, out_valid}), 64'd2);
    chk(out_quot == 0 && out_rem == 0, "R9 reset results", out_quot | out_rem, 64'd0);
    rst_n = 1'b1;
    // directed corners
    run_op(64'd5, 64'hDEAD_BEEF, 64'd0, 8'd0, 0, 0, 0, 0, "R5 zero divisor");
    run_op(64'd7, 64'h1234, 64'd7, 8'd0, 0, 0, 0, 0, "R4 D equals divisor");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd3, 8'd0, 0, 0, 0, 0, "R4 D above divisor");
    run_op(64'd0, 64'd1000, 64'd0, 8'd0, 1, 0, 0, 0, "R5 zero immediate");
    run_op(64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 0, 0, 1, 0, "R3 divide by one");
    run_op(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
           8'd0, 0, 0, 0, 0, "R3 maximal dividend");
    run_op(64'd200, rnd64(), 64'd3, 8'd201, 1, 1, 0, 0, "R6 immediate with junk");
    for (int t = 0; t < 64; t += 9)
      run_op(64'd0, rnd64(), 64'd1 << t, 8'd0, 0, 0, 1, t, "R7 power of two");
    // constrained random
    for (int k = 0; k < 40; k++) begin
      z = rnd64() >> ($urandom() % 64);
      d = (z != 0 && ($urandom() % 4) != 0) ? rnd64() % z : rnd64();
      if (k % 5 == 0) begin
        z = 64'($urandom() % 256);
        d = (z != 0) ? rnd64() % z : 64'd3;
        run_op(d, rnd64(), rnd64(), z[7:0], 1, k[0], 0, 0, "R6 random immediate");
      end else begin
        run_op(d, rnd64(), z, 8'($urandom()), 0, k[0], 0, 0, (d >= z) ? "R4 random" : "R3 random");
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule